// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A single control word carries three fields. The first is an 8-bit linear divisor. The second is a 4-bit power-of-two exponent. The third is one select bit that picks which of the two fields sets the rate. In linear mode the serial clock runs at the module clock divided by 2(n+1). In power-of-two mode it runs at the module clock divided by 2^(n+1). Either way the duty cycle is 50%. Software computes the field values; this block only applies them.

Alongside the clock level, the block emits two strobes, each one module clock wide, for the shift logic. One marks the leading edge, where the clock leaves its idle level. The other marks the trailing edge, where the clock returns to it. While the run enable is low, the serial clock rests at the requested polarity level. The divider fields and the polarity are captured only while the clock is idle, so a setting cannot change partway through a burst.

Top module: `dual_sck_divider`

## Requirements
- R1: While reset (rstN low) is asserted, sck, leadStrobe and trailStrobe are all 0.
- R2: While runEn is low, each clock edge sets sck to the present cpol input, and neither strobe is raised.
- R3: With clkCtrl[12]=1 (linear mode), every half period of sck lasts n+1 module clocks, where n = clkCtrl[7:0].
- R4: With clkCtrl[12]=0 (power-of-two mode), every half period of sck lasts 2^n module clocks, where n = clkCtrl[11:8].
- R5: The first edge of sck after a start comes exactly one half period after the first clock edge that samples runEn high. Until then sck holds the polarity level.
- R6: Changes to clkCtrl or cpol while runEn stays high alter neither the sck timing nor its polarity. The values sampled at the start edge stay in force until the next start.
- R7: leadStrobe is 1 for exactly the cycle in which sck first shows the level opposite the captured polarity. trailStrobe is 1 for exactly the cycle in which sck returns to the polarity level. The two are never high together.
- R8: When runEn drops, the next clock edge returns sck to the present cpol and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable; high produces clock, low parks it |
| cpol | input | 1 | Idle level of sck |
| clkCtrl | input | 13 | [7:0] linear divisor, [11:8] exponent, [12] 1 = linear, 0 = power-of-two |
| sck | output | 1 | Serial clock level |
| leadStrobe | output | 1 | One-cycle pulse with each transition away from idle |
| trailStrobe | output | 1 | One-cycle pulse with each transition back to idle |

## Verification
The assertions assume that reset is released only while runEn is low. They also assume that clkCtrl and cpol are settled at each clock edge; the block does no synchronisation. The bench drives every input on the falling clock edge. It opens each burst with runEn low for two cycles, so the start edge always finds an idle block. Mid-burst, it scrambles clkCtrl and cpol freely, because R6 requires that these changes have no effect.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

  // Per-cycle command from the control to the clock datapath.
  typedef struct packed {
    logic hold;    // idle: park sck at polarity, capture polarity
    logic toggle;  // half period elapsed: flip sck this edge
  } sckCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sckgen_ctrl.sv
module sckgen_ctrl
  import sckgen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   runEn,
  input  logic [LIN_W+EXP_W:0]   clkCtrl,
  output sckCtl_t                ctl
);

  // Wide enough for the largest half-period minus one in either mode.
  localparam int CNT_W   = maxOf(LIN_W, (1 << EXP_W) - 1);
  localparam int EXP_LSB = LIN_W;
  localparam int SEL_BIT = LIN_W + EXP_W;

  logic             active;
  logic [LIN_W-1:0] linS;
  logic [EXP_W-1:0] expS;
  logic             selS;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfM1;
  logic [CNT_W-1:0] powM1;
  logic             idle;
  logic             tick;

  // 2^n - 1; at the top exponent the shift wraps to zero and the
  // subtraction yields the all-ones limit, which is the wanted value.
  always_comb begin
    powM1  = ({{(CNT_W-1){1'b0}}, 1'b1} << expS) - {{(CNT_W-1){1'b0}}, 1'b1};
    halfM1 = selS ? CNT_W'(linS) : powM1;
  end

  assign idle = !runEn || !active;
  assign tick = !idle && (cnt == halfM1);

  always_comb begin
    ctl.hold   = idle;
    ctl.toggle = tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      linS   <= '0;
      expS   <= '0;
      selS   <= 1'b0;
      cnt    <= '0;
    end else begin
      active <= runEn;
      if (idle) begin
        cnt  <= '0;
        linS <= clkCtrl[LIN_W-1:0];
        expS <= clkCtrl[EXP_LSB +: EXP_W];
        selS <= clkCtrl[SEL_BIT];
      end else if (tick) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= halfM1);  // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runEn && active) && runEn && active) |-> $stable({selS, expS, linS}));  // R6

endmodule

// File: rtl/sckgen_dp.sv
module sckgen_dp
  import sckgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpol,
  input  sckCtl_t ctl,
  output logic    sck,
  output logic    leadStrobe,
  output logic    trailStrobe
);

  logic polQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck         <= 1'b0;
      polQ        <= 1'b0;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else if (ctl.hold) begin
      sck         <= cpol;
      polQ        <= cpol;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else begin
      leadStrobe  <= ctl.toggle && (sck == polQ);
      trailStrobe <= ctl.toggle && (sck != polQ);
      if (ctl.toggle) sck <= ~sck;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStrobe && trailStrobe));  // R7

  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (leadStrobe || trailStrobe) |-> !$stable(sck));  // R7

  AST_LEAD_AWAY: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe |-> (sck != polQ));  // R7

endmodule

// File: rtl/dual_sck_divider.sv
module dual_sck_divider
  import sckgen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic                 cpol,
  input  logic [LIN_W+EXP_W:0] clkCtrl,
  output logic                 sck,
  output logic                 leadStrobe,
  output logic                 trailStrobe
);

  sckCtl_t ctl;

  sckgen_ctrl #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .clkCtrl (clkCtrl),
    .ctl     (ctl)
  );

  sckgen_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpol        (cpol),
    .ctl         (ctl),
    .sck         (sck),
    .leadStrobe  (leadStrobe),
    .trailStrobe (trailStrobe)
  );

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (sck == $past(cpol)) && !leadStrobe && !trailStrobe);  // R2

  AST_RESET_QUIET: assert final (rstN || (!sck && !leadStrobe && !trailStrobe));  // R1

endmodule

// File: tb/dual_sck_divider_tb.sv
`timescale 1ns/1ps
module dual_sck_divider_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] clkCtrl = '0;
  logic        sck, leadStrobe, trailStrobe;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  dual_sck_divider u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cpol(cpol), .clkCtrl(clkCtrl),
    .sck(sck), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
  );

  function automatic int halfLen(input logic [12:0] c);
    return c[12] ? (int'(c[7:0]) + 1) : (1 << c[11:8]);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic runBurst(input logic [12:0] cfg, input logic pol, input int halves,
                          input bit perturb, input string tag);
    int h;
    int total;
    logic rp;
    h = halfLen(cfg);
    total = halves * h;
    @(negedge clk);
    runEn = 1'b0; cpol = pol; clkCtrl = cfg;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "idle sck", sck, pol);
    runEn = 1'b1;
    for (int k = 0; k <= total; k++) begin
      int ph;
      bit onEdge;
      @(negedge clk);
      ph = (k / h) & 1;
      onEdge = (k > 0) && (k % h == 0);
      chk((k <= h) ? "R5" : tag, "sck", sck, pol ^ ph[0]);
      chk("R7", "lead", leadStrobe, onEdge && ph == 1);
      chk("R7", "trail", trailStrobe, onEdge && ph == 0);
      if (perturb) begin
        clkCtrl = 13'($urandom);
        cpol = 1'($urandom);
      end
    end
    rp = 1'($urandom);
    runEn = 1'b0; cpol = rp;
    @(negedge clk);
    chk("R8", "stop sck", sck, rp);
    chk("R8", "stop strobes", leadStrobe | trailStrobe, 0);
  endtask

  initial begin
    #3000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset sck", sck, 0);
    chk("R1", "reset strobes", leadStrobe | trailStrobe, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2", "idle follows cpol=1", sck, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk("R2", "idle follows cpol=0", sck, 0);
    chk("R2", "idle strobes", leadStrobe | trailStrobe, 0);

    runBurst({1'b1, 4'd0, 8'd0},   1'b0, 6, 1'b0, "R3");
    runBurst({1'b1, 4'd9, 8'd3},   1'b1, 5, 1'b0, "R3");
    runBurst({1'b1, 4'd0, 8'd255}, 1'b1, 3, 1'b0, "R3");
    runBurst({1'b0, 4'd0, 8'd77},  1'b1, 6, 1'b0, "R4");
    runBurst({1'b0, 4'd3, 8'd0},   1'b0, 5, 1'b0, "R4");
    runBurst({1'b0, 4'd10, 8'd5},  1'b0, 3, 1'b0, "R4");
    runBurst({1'b1, 4'd2, 8'd5},   1'b0, 6, 1'b1, "R6");
    runBurst({1'b0, 4'd2, 8'd200}, 1'b1, 6, 1'b1, "R6");

    for (int i = 0; i < 20; i++) begin
      logic [12:0] c;
      c = 13'($urandom);
      if (!c[12]) c[11:8] = 4'($urandom_range(0, 7));
      runBurst(c, 1'($urandom), 4 + $urandom_range(0, 2), 1'($urandom),
               c[12] ? "R3" : "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule